// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a free-running counter with one input-capture channel, one output-compare channel and wrap detection. It is exposed as eight byte-wide registers on a simple read/write strobe bus, drives a compare output pin, samples a capture input pin and raises a level-sensitive timer interrupt. The counter moves forward only on cycles where the `tick` enable is high. The prescaler that produces `tick` sits outside the block.

Each of the three event flags clears in two steps. First, software reads the status register while the flag is set. Second, it accesses the low byte of the register that belongs to that flag. An access to the low byte that was not preceded by such a status read leaves the flag set. Reading the capture high byte or writing the compare high byte pauses that channel until the matching low byte is accessed, so a 16-bit value is never split across an event.

Register offsets, as driven on `bus_addr`: 0 control, 1 status, 2 capture high, 3 capture low, 4 compare high, 5 compare low, 6 counter high, 7 counter low.

Top module: `tmr_capcmp`

## Requirements
- R1: The counter adds one at each clock edge where `tick` is high and holds otherwise. Reset sets it to 0.
- R2: Reading the counter high byte stores the current low byte. The next counter low read returns that stored byte. A counter low read with no high read pending returns the live low byte.
- R3: When the counter steps from all ones to zero, status bit 5 (the wrap flag) is set.
- R4: When the capture pin changes to the level held in control bit 1, status bit 7 is set and the counter value is copied into the capture register. A change to the opposite level has no effect.
- R5: After a read of the capture high byte (offset 2), capture events are ignored until the capture low byte (offset 3) is read.
- R6: When a tick moves the counter onto the compare value, status bit 6 is set and `cmp_out` takes the value of control bit 0.
- R7: After a write of the compare high byte (offset 4), compare matches are ignored until the compare low byte (offset 5) is written.
- R8: A flag is cleared only by its low-byte access (capture flag: read offset 3; compare flag: write offset 5; wrap flag: read offset 7), and only if a status read saw that flag set earlier. A low-byte access on its own leaves the flag set.
- R9: `irq` is high exactly when one of status bits 7..5 is set and the enable in the same bit position of control is also set.
- R10: Reset clears control bits 7..5 and bit 0, keeps control bit 1, clears all flags and drives `cmp_out` low.
- R11: The control register reads back as {enables[7:5], 000, bit1, bit0}. The status register reads back as {flags[7:5], 00000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter step enable |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, with side effects at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cap_in | input | 1 | Capture pin, already synchronous to `clk` |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Timer interrupt level |

## Verification
The assertions assume that `cap_in` is already synchronous to `clk`, and that `bus_rd` and `bus_wr` are never high in the same cycle. The stimulus changes every input just after a rising edge and drives a single strobe at a time. It holds `tick` low during register accesses, so every expected counter value follows from the number of tick cycles issued. The wrap case runs the counter through its full range once. The compare value is placed so that a match also occurs during that run, which exercises two flags set together.

// File: rtl/tmr_pkg.sv
// Shared definitions for the capture/compare timer: register offsets and
// the position of each event flag inside the internal three-bit flag vector.
package tmr_pkg;
    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_CAPH = 3'd2,
        A_CAPL = 3'd3,
        A_CMPH = 3'd4,
        A_CMPL = 3'd5,
        A_CNTH = 3'd6,
        A_CNTL = 3'd7
    } tmr_addr_e;

    // flag vector index; maps to status/control bits 7, 6, 5
    localparam int F_CAP = 2;
    localparam int F_CMP = 1;
    localparam int F_OVF = 0;
    localparam int NFLAG = 3;
endpackage

// File: rtl/tmr_counter.sv
// Free-running counter with wrap detection and a buffered low byte, so that
// a high-then-low read returns one coherent value.
// Assumes rd_hi and rd_lo are never high together.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             wrap,
    output logic [CNT_W/2-1:0] lo_data
);
    localparam int BYTE_W = CNT_W / 2;

    logic [BYTE_W-1:0] lo_buf;
    logic              buf_vld;

    assign cnt_next = cnt + 1'b1;
    assign wrap     = tick && (&cnt);
    assign lo_data  = buf_vld ? lo_buf : cnt[BYTE_W-1:0];

    // advance the count on tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt_next;
    end

    // hold the low byte between a high read and the next low read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf  <= '0;
            buf_vld <= 1'b0;
        end else if (rd_hi) begin
            lo_buf  <= cnt[BYTE_W-1:0];
            buf_vld <= 1'b1;
        end else if (rd_lo) begin
            buf_vld <= 1'b0;
        end
    end

    // R1
    property p_hold;
        @(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt);
    endproperty
    cnt_hold_chk: assert property (p_hold);

    // R3
    property p_wrap;
        @(posedge clk) disable iff (!rst_n) wrap |=> (cnt == '0);
    endproperty
    wrap_zero_chk: assert property (p_wrap);
endmodule

// File: rtl/tmr_capture.sv
// Input-capture channel: detects a change of the capture pin to the selected
// level and copies the counter. A high-byte read pauses capture until the
// low byte is read. Assumes the pin is already synchronous to clk.
module tmr_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_sel,
    input  logic             pin,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_evt
);
    logic pin_q;
    logic inhibit;

    assign cap_evt = (pin != pin_q) && (pin == edge_sel) && !inhibit;

    // remember the previous pin level for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // pause capture between a high-byte read and a low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     inhibit <= 1'b0;
        else if (rd_lo) inhibit <= 1'b0;
        else if (rd_hi) inhibit <= 1'b1;
    end

    // store the counter on a qualified event
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= cnt;
    end

    // R4
    property p_copy;
        @(posedge clk) disable iff (!rst_n) cap_evt |=> (cap_val == $past(cnt));
    endproperty
    cap_copy_chk: assert property (p_copy);

    // R5
    property p_freeze;
        @(posedge clk) disable iff (!rst_n) (inhibit && !rd_lo) |=> $stable(cap_val);
    endproperty
    cap_freeze_chk: assert property (p_freeze);
endmodule

// File: rtl/tmr_compare.sv
// Output-compare channel: holds the compare value and flags a match when a
// tick brings the counter onto it, driving the pin to the programmed level.
// A high-byte write pauses matching until the low byte is written.
module tmr_compare #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [CNT_W-1:0]   cnt_next,
    input  logic               wr_hi,
    input  logic               wr_lo,
    input  logic [CNT_W/2-1:0] wdata,
    input  logic               level,
    output logic               match,
    output logic               pin_out
);
    localparam int BYTE_W = CNT_W / 2;

    logic [CNT_W-1:0] ocr;
    logic             inhibit;

    assign match = tick && !inhibit && (cnt_next == ocr);

    // load compare bytes and track the pending-high state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocr     <= '0;
            inhibit <= 1'b0;
        end else if (wr_hi) begin
            ocr[CNT_W-1:BYTE_W] <= wdata;
            inhibit             <= 1'b1;
        end else if (wr_lo) begin
            ocr[BYTE_W-1:0] <= wdata;
            inhibit         <= 1'b0;
        end
    end

    // drive the pin to the programmed level on a match
    always_ff @(posedge clk) begin
        if (!rst_n)     pin_out <= 1'b0;
        else if (match) pin_out <= level;
    end

    // R6
    property p_pin;
        @(posedge clk) disable iff (!rst_n) match |=> (pin_out == $past(level));
    endproperty
    cmp_pin_chk: assert property (p_pin);
endmodule

// File: rtl/tmr_capcmp.sv
// Capture/compare timer top: control and status registers, two-step flag
// clearing, read multiplexer and interrupt level.
// Assumes bus_rd and bus_wr are never high in the same cycle.
module tmr_capcmp #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [2:0]           bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [CNT_W/2-1:0]   bus_wdata,
    output logic [CNT_W/2-1:0]   bus_rdata,
    input  logic                 cap_in,
    output logic                 cmp_out,
    output logic                 irq
);
    import tmr_pkg::*;
    localparam int BYTE_W = CNT_W / 2;

    logic [NFLAG-1:0] flags, seen, en, set_v, clr_v;
    logic             lvl;
    logic             edge_sel = 1'b0;
    logic [CNT_W-1:0] cnt, cnt_next, cap_val;
    logic [BYTE_W-1:0] cnt_lo;
    logic             wrap, cap_evt, match;

    logic rd_stat, rd_caph, rd_capl, rd_cnth, rd_cntl, wr_ctrl, wr_cmph, wr_cmpl;
    assign rd_stat = bus_rd && (bus_addr == A_STAT);
    assign rd_caph = bus_rd && (bus_addr == A_CAPH);
    assign rd_capl = bus_rd && (bus_addr == A_CAPL);
    assign rd_cnth = bus_rd && (bus_addr == A_CNTH);
    assign rd_cntl = bus_rd && (bus_addr == A_CNTL);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_cmph = bus_wr && (bus_addr == A_CMPH);
    assign wr_cmpl = bus_wr && (bus_addr == A_CMPL);

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rd_hi(rd_cnth), .rd_lo(rd_cntl),
        .cnt(cnt), .cnt_next(cnt_next), .wrap(wrap), .lo_data(cnt_lo)
    );

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .pin(cap_in), .cnt(cnt),
        .rd_hi(rd_caph), .rd_lo(rd_capl), .cap_val(cap_val), .cap_evt(cap_evt)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_next(cnt_next),
        .wr_hi(wr_cmph), .wr_lo(wr_cmpl), .wdata(bus_wdata), .level(lvl),
        .match(match), .pin_out(cmp_out)
    );

    assign set_v[F_CAP] = cap_evt;
    assign set_v[F_CMP] = match;
    assign set_v[F_OVF] = wrap;
    assign clr_v[F_CAP] = rd_capl && seen[F_CAP];
    assign clr_v[F_CMP] = wr_cmpl && seen[F_CMP];
    assign clr_v[F_OVF] = rd_cntl && seen[F_OVF];

    // control bits that reset clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= '0;
            lvl <= 1'b0;
        end else if (wr_ctrl) begin
            en  <= bus_wdata[BYTE_W-1 -: NFLAG];
            lvl <= bus_wdata[0];
        end
    end

    // capture edge select, kept across reset
    always_ff @(posedge clk) begin
        if (rst_n && wr_ctrl) edge_sel <= bus_wdata[1];
    end

    // event flags: new events win over clearing
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    // record which flags a status read observed
    always_ff @(posedge clk) begin
        if (!rst_n)       seen <= '0;
        else if (rd_stat) seen <= flags;
        else              seen <= seen & ~clr_v;
    end

    // register read multiplexer
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {en, {(BYTE_W-NFLAG-2){1'b0}}, edge_sel, lvl};
            A_STAT:  bus_rdata = {flags, {(BYTE_W-NFLAG){1'b0}}};
            A_CAPH:  bus_rdata = cap_val[CNT_W-1:BYTE_W];
            A_CAPL:  bus_rdata = cap_val[BYTE_W-1:0];
            A_CNTH:  bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNTL:  bus_rdata = cnt_lo;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(en & flags);

    // R8
    property p_noclr;
        @(posedge clk) disable iff (!rst_n)
            (rd_cntl && !seen[F_OVF] && flags[F_OVF]) |=> flags[F_OVF];
    endproperty
    ovf_keep_chk: assert property (p_noclr);

    // R9
    property p_irq;
        @(posedge clk) disable iff (!rst_n) irq |-> (flags != '0);
    endproperty
    irq_src_chk: assert property (p_irq);
endmodule

// File: tb/tb_tmr_capcmp.sv
module tb_tmr_capcmp;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       cmp_out, irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    tmr_capcmp dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    // monitor: pop the expected read data and compare mid-cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", r, bus_rdata, e);
                end
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); req_q.push_back(r);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic step(input int n);
        @(posedge clk); #1;
        tick = 1'b1;
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    task automatic pin(input logic v);
        @(posedge clk); #1;
        cap_in = v;
        cyc(1);
    endtask

    task automatic chk(input logic act, input logic e, input string r);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", r, act, e);
        end
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        wr(3'd0, 8'hE3);
        @(posedge clk); #1; rst_n = 1'b0;
        cyc(1); rst_n = 1'b1;
        // R10 R11: reset keeps only control bit 1
        rd(3'd0, 8'h02, "R10 ctrl after reset");
        rd(3'd1, 8'h00, "R10 status after reset");
        chk(cmp_out, 1'b0, "R10 cmp_out after reset");
        chk(irq, 1'b0, "R9 irq after reset");
        rd(3'd6, 8'h00, "R1 counter high after reset");
        rd(3'd7, 8'h00, "R1 counter low after reset");

        // R1 R2: counting and coherent read
        step(5);
        rd(3'd6, 8'h00, "R1 counter high");
        rd(3'd7, 8'h05, "R1 counter low after 5 ticks");
        rd(3'd6, 8'h00, "R2 high read latches low");
        step(300);
        rd(3'd7, 8'h05, "R2 buffered low byte");
        rd(3'd7, 8'h31, "R2 live low byte");

        // R4: rising edge capture at count 0x0131
        pin(1'b1);
        rd(3'd1, 8'h80, "R4 capture flag set");
        rd(3'd2, 8'h01, "R4 capture high");
        rd(3'd3, 8'h31, "R4 capture low");
        rd(3'd1, 8'h00, "R8 capture flag cleared");
        pin(1'b0);
        rd(3'd1, 8'h00, "R4 opposite edge ignored");

        // R4 R8: falling edge select, low read alone keeps flag
        wr(3'd0, 8'h00);
        step(10);
        pin(1'b1);
        pin(1'b0);
        rd(3'd3, 8'h3B, "R4 falling capture low");
        rd(3'd1, 8'h80, "R8 low read without status keeps flag");
        rd(3'd3, 8'h3B, "R8 clearing low read");
        rd(3'd1, 8'h00, "R8 flag cleared after two steps");

        // R5: capture paused after high read
        rd(3'd2, 8'h01, "R5 capture high read");
        step(5);
        pin(1'b1);
        pin(1'b0);
        rd(3'd1, 8'h00, "R5 no flag while paused");
        rd(3'd3, 8'h3B, "R5 capture value held");
        pin(1'b1);
        pin(1'b0);
        rd(3'd1, 8'h80, "R5 capture resumes");
        rd(3'd3, 8'h40, "R5 new capture value");
        rd(3'd1, 8'h00, "R8 capture flag cleared again");

        // R6 R9: compare at 0x0148, level 1
        wr(3'd0, 8'h41);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h48);
        step(8);
        chk(cmp_out, 1'b1, "R6 pin driven high");
        chk(irq, 1'b1, "R9 irq with compare enabled");
        rd(3'd1, 8'h40, "R6 compare flag set");
        wr(3'd0, 8'h01);
        chk(irq, 1'b0, "R9 irq masked");
        wr(3'd0, 8'h41);
        chk(irq, 1'b1, "R9 irq unmasked");
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h50);
        chk(irq, 1'b0, "R8 compare flag cleared by low write");
        rd(3'd1, 8'h00, "R8 compare flag clear");

        // R7: compare paused after high write
        wr(3'd0, 8'h40);
        wr(3'd4, 8'h01);
        step(10);
        rd(3'd1, 8'h00, "R7 no match while paused");
        chk(cmp_out, 1'b1, "R7 pin unchanged while paused");
        wr(3'd5, 8'h5A);
        step(8);
        chk(cmp_out, 1'b0, "R6 pin driven low");
        rd(3'd1, 8'h40, "R6 compare flag after resume");
        wr(3'd5, 8'hFF);
        rd(3'd1, 8'h00, "R8 compare flag cleared");

        // R3: wrap from all ones to zero
        wr(3'd0, 8'h20);
        step(65536 - 346);
        chk(irq, 1'b1, "R3 irq on wrap");
        rd(3'd7, 8'h00, "R1 counter low after wrap");
        rd(3'd1, 8'h60, "R8 wrap flag kept after lone low read");
        rd(3'd6, 8'h00, "R1 counter high after wrap");
        rd(3'd7, 8'h00, "R3 clearing low read");
        rd(3'd1, 8'h40, "R3 wrap flag cleared");
        chk(irq, 1'b0, "R9 irq after wrap clear");

        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule